// File: doc/BRIEF.md
# Byte-Loaded SPI Master with Programmable Clock Rate

This block is a single-peripheral SPI master. Each transfer is one 16-bit full-duplex frame, sent and received most significant bit first. A host on the same chip reaches it through an 8-bit parallel port. The host sets the serial clock rate, the serial clock idle level and the chip-select polarity with a single configuration byte. It loads the outgoing word as two bytes, starts the frame with a one-cycle pulse and waits for `busy` to fall. It then reads the reply as two bytes from the same register that held the outgoing word.

The write strobe and the start pulse are registered once before the block acts on them. The byte, the byte select and the configuration qualifier are registered together with the write strobe, so all of them stay aligned. The serial clock, chip select and MOSI are driven from flip-flops, so the pins cannot glitch. The serial clock idles at the configured polarity. Data moves out on the edge that leaves the idle level, and the reply bit is captured on the edge that returns to it. The half-period is a power of two of system clocks, chosen by a 4-bit rate field.

Top module: `spi_byte_master`

## Requirements
- R1: After reset `busy` is 0, both bytes of the data register read 0 and the configuration is 0. The serial clock therefore rests at 0 and chip select rests at 1.
- R2: A write with `host_cfg`=1 loads the configuration byte. Bits [3:0] are the rate field n, bit 4 makes chip select active high when 1, and bit 5 is the serial clock idle level. Bits [7:6] have no effect.
- R3: A write with `host_cfg`=0 while idle loads `host_wdata` into the high byte [15:8] when `host_hi_sel`=1, or into the low byte [7:0] when it is 0. `host_rdata` shows the byte selected by `host_hi_sel` with no delay.
- R4: A frame sends the 16-bit register on `spi_mosi` MSB first. In the same frame the 16 bits from `spi_miso` are collected into the register, with the first bit received ending up in bit 15. The register can be read once `busy` has fallen.
- R5: Every serial clock half-period lasts 2^n system clocks, so the clock is divided by 2^(n+1). A frame contains exactly 32 serial clock edges.
- R6: `spi_mosi` changes only together with a serial clock edge that leaves the idle level. `spi_miso` is captured on the edge that returns to the idle level.
- R7: While no frame is running, `spi_sclk` holds the configured idle level and `spi_cs` holds the inactive level of the configured polarity.
- R8: While `busy` is high, chip select is active. It becomes active one half-period before the first serial clock edge and returns to inactive one half-period after the last edge.
- R9: While `busy` is high, start pulses and data-register writes have no effect. A start pulse given during a frame is not held over to start another frame afterwards.
- R10: `busy` rises on the second rising clock edge after `host_start` is first sampled high. `spi_cs` becomes active one clock after `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wdata | input | 8 | Byte written by the host |
| host_wr | input | 1 | Write strobe for the configuration or data register |
| host_hi_sel | input | 1 | Byte select: 1 = bits [15:8], 0 = bits [7:0] |
| host_cfg | input | 1 | 1 sends a write to the configuration register |
| host_start | input | 1 | Start pulse for a frame |
| host_rdata | output | 8 | Selected byte of the data register |
| busy | output | 1 | High while a frame is in progress |
| spi_cs | output | 1 | Chip select, polarity set by the configuration |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume the configuration byte is not rewritten while `busy` is high, because the chip-select and clock-level checks compare the pins against the current configuration. The stimulus writes the configuration only between frames and waits two clocks before it looks at the idle pin levels. The assertions also assume that `spi_miso` changes only between a leading edge and the following trailing edge. The bench's peripheral model changes `spi_miso` only on the falling system clock edge that follows an observed leading edge. Rate fields are kept small (up to 6) so that each frame stays short.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

    localparam int BUS_W    = 8;
    localparam int FRAME_W  = 16;
    localparam int SEL_W    = 4;
    localparam int CNT_W    = 1 << SEL_W;
    localparam int EDGES    = 2 * FRAME_W;
    localparam int EDGE_W   = $clog2(EDGES);
    localparam int CSHI_BIT = SEL_W;
    localparam int CPOL_BIT = SEL_W + 1;
    localparam int CFG_BITS = SEL_W + 2;

    typedef struct packed {
        logic             cpol;
        logic             cs_hi;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    typedef struct packed {
        logic             wr;
        logic             start;
        logic             cfg_sel;
        logic             hi_sel;
        logic [BUS_W-1:0] data;
    } host_req_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } xfer_st_t;

    function automatic logic cs_level(input logic active, input logic cs_hi);
        return active ? cs_hi : ~cs_hi;
    endfunction

    function automatic logic [CNT_W-1:0] half_limit(input logic [SEL_W-1:0] sel);
        return (CNT_W'(1) << sel) - CNT_W'(1);
    endfunction

endpackage

// File: rtl/spi_bm_sync.sv
module spi_bm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/spi_bm_cfg.sv
module spi_bm_cfg
    import spi_bm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic                cfg_sel,
    input  logic [CFG_BITS-1:0] bits,
    output cfg_t                cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr && cfg_sel) begin
            cfg_q.cpol  <= bits[CPOL_BIT];
            cfg_q.cs_hi <= bits[CSHI_BIT];
            cfg_q.sel   <= bits[SEL_W-1:0];
        end
    end
endmodule

// File: rtl/spi_bm_rate.sv
module spi_bm_rate
    import spi_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = half_limit(sel);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine
    import spi_bm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  host_req_t          req,
    input  logic               cpol,
    input  logic               tick,
    input  logic               miso,
    output logic               busy,
    output logic               sclk_int,
    output logic               mosi_q,
    output logic [FRAME_W-1:0] data_q
);
    localparam int HI_OFF = FRAME_W - BUS_W;

    xfer_st_t           st_q, st_d;
    logic               phase_q;
    logic [EDGE_W-1:0]  ecnt_q;
    logic               samp_q;
    logic               lead_edge, trail_edge, last_edge;
    logic [FRAME_W-1:0] data_d;

    assign busy       = (st_q != ST_IDLE);
    assign sclk_int   = cpol ^ phase_q;
    assign lead_edge  = tick && !phase_q && (st_q == ST_LEAD || st_q == ST_SHIFT);
    assign trail_edge = tick && phase_q && (st_q == ST_SHIFT);
    assign last_edge  = trail_edge && (ecnt_q == EDGE_W'(EDGES - 1));

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (req.start) st_d = ST_LEAD;
            ST_LEAD:  if (tick)      st_d = ST_SHIFT;
            ST_SHIFT: if (last_edge) st_d = ST_TRAIL;
            ST_TRAIL: if (tick)      st_d = ST_IDLE;
            default:                 st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        data_d = data_q;
        if (samp_q)    data_d[0] = miso;
        if (lead_edge) data_d = data_d << 1;
        if (st_q == ST_IDLE && req.wr && !req.cfg_sel) begin
            if (req.hi_sel) data_d[HI_OFF +: BUS_W] = req.data;
            else            data_d[0 +: BUS_W]      = req.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            phase_q <= 1'b0;
            ecnt_q  <= '0;
            samp_q  <= 1'b0;
            mosi_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            st_q   <= st_d;
            samp_q <= trail_edge;
            data_q <= data_d;
            if (lead_edge) mosi_q <= data_q[FRAME_W-1];
            if (lead_edge || trail_edge) begin
                phase_q <= ~phase_q;
                ecnt_q  <= ecnt_q + EDGE_W'(1);
            end else if (st_q == ST_IDLE) begin
                phase_q <= 1'b0;
                ecnt_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/spi_bm_pins.sv
module spi_bm_pins
    import spi_bm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic cs_hi,
    input  logic sclk_int,
    input  logic mosi_int,
    output logic cs_pin,
    output logic sclk_pin,
    output logic mosi_pin
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_pin   <= 1'b1;
            sclk_pin <= 1'b0;
            mosi_pin <= 1'b0;
        end else begin
            cs_pin   <= cs_level(active, cs_hi);
            sclk_pin <= sclk_int;
            mosi_pin <= mosi_int;
        end
    end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] host_wdata,
    input  logic             host_wr,
    input  logic             host_hi_sel,
    input  logic             host_cfg,
    input  logic             host_start,
    output logic [BUS_W-1:0] host_rdata,
    output logic             busy,
    output logic             spi_cs,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    host_req_t          req_raw, req_s;
    cfg_t               cfg_q;
    logic               tick;
    logic               sclk_int, mosi_q;
    logic [FRAME_W-1:0] data_q;

    assign req_raw = '{wr: host_wr, start: host_start, cfg_sel: host_cfg,
                       hi_sel: host_hi_sel, data: host_wdata};

    spi_bm_sync #(.W($bits(host_req_t))) u_sync (
        .clk(clk), .rst(rst), .d(req_raw), .q(req_s)
    );

    spi_bm_cfg u_cfg (
        .clk(clk), .rst(rst), .wr(req_s.wr), .cfg_sel(req_s.cfg_sel),
        .bits(req_s.data[CFG_BITS-1:0]), .cfg_q(cfg_q)
    );

    spi_bm_rate u_rate (
        .clk(clk), .rst(rst), .run(busy), .sel(cfg_q.sel), .tick(tick)
    );

    spi_bm_engine u_eng (
        .clk(clk), .rst(rst), .req(req_s), .cpol(cfg_q.cpol), .tick(tick),
        .miso(spi_miso), .busy(busy), .sclk_int(sclk_int), .mosi_q(mosi_q),
        .data_q(data_q)
    );

    spi_bm_pins u_pins (
        .clk(clk), .rst(rst), .active(busy), .cs_hi(cfg_q.cs_hi),
        .sclk_int(sclk_int), .mosi_int(mosi_q),
        .cs_pin(spi_cs), .sclk_pin(spi_sclk), .mosi_pin(spi_mosi)
    );

    assign host_rdata = host_hi_sel ? data_q[FRAME_W-1 -: BUS_W] : data_q[BUS_W-1:0];
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
    import spi_bm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             spi_cs,
    input logic             spi_sclk,
    input logic             spi_mosi,
    input logic [BUS_W-1:0] host_rdata,
    input cfg_t             cfg
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && spi_cs && !spi_sclk && host_rdata == '0));

    // R7
    idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> (spi_cs == !$past(cfg.cs_hi)));

    // R7
    idle_sclk_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> (spi_sclk == $past(cfg.cpol)));

    // R8
    cs_active_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (spi_cs == cfg.cs_hi));

    // R6
    mosi_on_lead_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_mosi) |-> (!$stable(spi_sclk) && spi_sclk != cfg.cpol));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .spi_cs(spi_cs), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .host_rdata(host_rdata), .cfg(cfg_q)
);

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0;
    logic       host_hi_sel = 1'b0;
    logic       host_cfg = 1'b0;
    logic       host_start = 1'b0;
    logic [7:0] host_rdata;
    logic       busy, spi_cs, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    always #5 clk = ~clk;

    spi_byte_master uut (
        .clk(clk), .rst(rst), .host_wdata(host_wdata), .host_wr(host_wr),
        .host_hi_sel(host_hi_sel), .host_cfg(host_cfg), .host_start(host_start),
        .host_rdata(host_rdata), .busy(busy), .spi_cs(spi_cs), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // {config byte, word sent, reply from peripheral}
    localparam logic [39:0] VEC [6] = '{
        {8'h20, 16'h0700, 16'hA55A},
        {8'h00, 16'hFFFF, 16'h0000},
        {8'h11, 16'h8001, 16'h1234},
        {8'h33, 16'h5AA5, 16'hFFFF},
        {8'hC2, 16'h0001, 16'h8000},
        {8'h26, 16'h1357, 16'hC3E1}
    };

    // peripheral model and timing monitor state
    logic        cur_cpol = 1'b0;
    logic        cur_cs_hi = 1'b0;
    logic [15:0] reply = '0;
    logic [15:0] rx_cap = '0;
    logic        prev_sclk = 1'b0;
    logic        prev_act = 1'b0;
    int          run = 0, edges = 0, lead = 0, tail = 0, minrun = 0, maxrun = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = spi_sclk;
            prev_act  = 1'b0;
        end else begin
            logic act;
            act = (spi_cs == cur_cs_hi);
            run++;
            if (act && !prev_act) begin
                run = 0; edges = 0; minrun = 1 << 30; maxrun = 0; rx_cap = '0;
            end else if (!act && prev_act) begin
                tail = run;
            end
            if (act && spi_sclk != prev_sclk) begin
                if (edges == 0) lead = run;
                else begin
                    if (run < minrun) minrun = run;
                    if (run > maxrun) maxrun = run;
                end
                if (spi_sclk != cur_cpol) spi_miso = reply[15 - edges / 2];
                else                      rx_cap = {rx_cap[14:0], spi_mosi};
                edges++;
                run = 0;
            end
            prev_sclk = spi_sclk;
            prev_act  = act;
        end
    end

    task automatic host_write(input logic c, input logic hi, input logic [7:0] d);
        host_cfg = c; host_hi_sel = hi; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_cfg = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start;
        host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
    endtask

    task automatic wait_idle;
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_word(output logic [15:0] w);
        host_hi_sel = 1'b1; #1; w[15:8] = host_rdata;
        host_hi_sel = 1'b0; #1; w[7:0]  = host_rdata;
    endtask

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 sclk", spi_sclk, 0);
        chk("R1 cs", spi_cs, 1);
        read_word(w);
        chk("R1 data", w, 16'h0000);

        for (int i = 0; i < 6; i++) begin
            logic [7:0]  c;
            logic [15:0] tx, rx;
            int          h;
            {c, tx, rx} = VEC[i];
            h = 1 << c[3:0];
            cur_cpol = c[5]; cur_cs_hi = c[4]; reply = rx;
            host_write(1'b1, 1'b0, c);
            host_write(1'b0, 1'b1, tx[15:8]);
            host_write(1'b0, 1'b0, tx[7:0]);
            read_word(w);
            chk("R3 readback", w, tx);
            // R2 bits 7:6 ignored, R7 idle levels
            chk("R7 idle sclk", spi_sclk, c[5]);
            chk("R7 idle cs", spi_cs, !c[4]);
            pulse_start();
            wait_idle();
            chk("R4 mosi word", rx_cap, tx);
            read_word(w);
            chk("R4 miso word", w, rx);
            chk("R5 edge count", edges, 32);
            chk("R5 min half", minrun, h);
            chk("R5 max half", maxrun, h);
            chk("R8 lead gap", lead, h);
            chk("R8 tail gap", tail, h);
            chk("R2 idle sclk after", spi_sclk, c[5]);
        end

        // R10: start to busy and chip select latency (config 0x11 active high)
        cur_cpol = 1'b0; cur_cs_hi = 1'b1; reply = 16'h6C39;
        host_write(1'b1, 1'b0, 8'h11);
        host_write(1'b0, 1'b1, 8'hF0);
        host_write(1'b0, 1'b0, 8'h0F);
        host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
        chk("R10 busy after 1", busy, 0);
        @(negedge clk);
        chk("R10 busy after 2", busy, 1);
        chk("R10 cs not yet", spi_cs, 0);
        @(negedge clk);
        chk("R10 cs active", spi_cs, 1);

        // R9: write and start during the frame are ignored
        repeat (4) @(negedge clk);
        host_write(1'b0, 1'b1, 8'h99);
        pulse_start();
        wait_idle();
        read_word(w);
        chk("R9 write ignored", w, 16'h6C39);
        chk("R9 mosi word", rx_cap, 16'hF00F);
        repeat (12) @(negedge clk);
        chk("R9 no restart", busy, 0);
        chk("R9 cs idle", spi_cs, 0);

        // R2: upper bits 0xC0 alone change nothing from all-zero config
        host_write(1'b1, 1'b0, 8'hC0);
        @(negedge clk);
        chk("R2 ignored bits sclk", spi_sclk, 0);
        chk("R2 ignored bits cs", spi_cs, 1);

        summary();
        $finish;
    end
endmodule